// File: doc/BRIEF.md
# Accelerator Control Register Block

This block is the host-facing control front of a hardware accelerator. A processor reaches it over an AXI4-Lite slave port and uses four 32-bit registers to launch the accelerator core, follow its progress and take interrupts from it. Toward the core it drives a start request and receives done, idle and ready indications. A single interrupt line goes to the system interrupt controller.

The start request is set by software and withdrawn by hardware once the core accepts it. Completion and acceptance events are caught in sticky flags that a read of the control register clears. A free-running mode re-launches the core after every completion. Two enable layers sit between the core's events and the interrupt line: a per-source enable register and a global enable. Each source sets its bit in a status register that a read of that register clears.

Top module: `accel_ctrl_regs`

## Requirements
- R1: A write is taken in a cycle where AW and W are both valid and no write response is pending; B becomes valid in the next cycle with response 2'b00 and stays valid until BREADY. A read is taken in a cycle where ARVALID is high and no read data is pending; R becomes valid in the next cycle with response 2'b00, and RDATA stays stable until RREADY.
- R2: Writing 1 to bit 0 of offset 0x0 raises `core_start` in the next cycle. Writing 0 to that bit leaves it unchanged. `core_start` falls in the cycle after one where it is high and `core_ready` is high, unless a new set arrives in that same cycle.
- R3: Bit 1 of 0x0 (completion flag) sets on `core_done`. Bit 3 of 0x0 (acceptance flag) sets on a cycle with `core_start` and `core_ready` both high. Both flags hold until a read of 0x0 is taken. That read returns the value from before the clear. An event in the same cycle as the clearing read leaves the flag set.
- R4: Bit 2 of 0x0 returns `core_idle` as it was in the cycle the read was taken. Bit 0 of 0x0 reads the current start request.
- R5: Bit 7 of 0x0 is a read/write free-running mode bit. While it is set, `core_done` raises `core_start` in the next cycle.
- R6: Offset 0x4 bit 0 is the global interrupt enable. Offset 0x8 bit 0 enables the completion source and bit 1 enables the acceptance source. Both registers read back what was written, and all other bits read 0.
- R7: Offset 0xC bit 0 sets on `core_done` and bit 1 sets on an acceptance, each only when its enable bit in 0x8 is already set. A read of 0xC clears both bits, returning the value from before the clear. A new event in the same cycle wins over the clear. Writes to 0xC have no effect.
- R8: `irq` is high exactly when the global enable is set and any bit of 0xC is set. Bit 9 of 0x0 reads the same value.
- R9: Every writable bit lives in byte lane 0. A write with WSTRB bit 0 low changes no register and still gets a response.
- R10: Any address with a bit set above bit 3 reads as 0 with an OKAY response. A write to such an address changes nothing and gets an OKAY response.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| s_awaddr | input | ADDR_W | Write address |
| s_awvalid | input | 1 | Write address valid |
| s_awready | output | 1 | Write address ready |
| s_wdata | input | DATA_W | Write data |
| s_wstrb | input | DATA_W/8 | Write byte strobes |
| s_wvalid | input | 1 | Write data valid |
| s_wready | output | 1 | Write data ready |
| s_bresp | output | 2 | Write response |
| s_bvalid | output | 1 | Write response valid |
| s_bready | input | 1 | Write response ready |
| s_araddr | input | ADDR_W | Read address |
| s_arvalid | input | 1 | Read address valid |
| s_arready | output | 1 | Read address ready |
| s_rdata | output | DATA_W | Read data |
| s_rresp | output | 2 | Read response |
| s_rvalid | output | 1 | Read data valid |
| s_rready | input | 1 | Read data ready |
| core_start | output | 1 | Start request to the core |
| core_done | input | 1 | Core completion pulse |
| core_idle | input | 1 | Core idle level |
| core_ready | input | 1 | Core accepts the start request |
| irq | output | 1 | Interrupt request |

## Verification
The risky overlap is a clearing read landing on the same edge as a new core event. A read of 0x0 can meet a `core_done` pulse, and a read of 0xC can meet a completion or acceptance. One directed case drives `core_done` high in exactly the cycle the read of 0x0 is taken. It then expects the old flag value in that read's data and the flag still set in the next read. A long random phase issues reads to all offsets while the core pulses done and ready at random. In that phase a reference model, updated on every edge, judges each flag, the start line and the interrupt line.

// File: rtl/accel_ctrl_pkg.sv
package accel_ctrl_pkg;

   typedef enum logic [1:0] {
      REG_CTRL = 2'd0,
      REG_GIE  = 2'd1,
      REG_IER  = 2'd2,
      REG_ISR  = 2'd3
   } reg_sel_e;

   localparam int unsigned B_START = 0;
   localparam int unsigned B_DONE  = 1;
   localparam int unsigned B_IDLE  = 2;
   localparam int unsigned B_READY = 3;
   localparam int unsigned B_AUTO  = 7;
   localparam int unsigned B_IRQ   = 9;

   localparam int unsigned N_SRC = 2;

   localparam logic [1:0] RESP_OKAY = 2'b00;

endpackage

// File: rtl/axil_wr_port.sv
module axil_wr_port
   import accel_ctrl_pkg::*;
#(
   parameter int ADDR_W = 6,
   parameter int DATA_W = 32,
   localparam int STRB_W = DATA_W / 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] awaddr,
   input  logic              awvalid,
   output logic              awready,
   input  logic [DATA_W-1:0] wdata,
   input  logic [STRB_W-1:0] wstrb,
   input  logic              wvalid,
   output logic              wready,
   output logic [1:0]        bresp,
   output logic              bvalid,
   input  logic              bready,
   output logic              wr_en,
   output logic [ADDR_W-1:2] wr_word,
   output logic [7:0]        wr_byte0,
   output logic              wr_lane0
);

   logic bvalid_q;
   logic unused_wr_bits;

   assign wr_en    = awvalid & wvalid & ~bvalid_q;
   assign awready  = wr_en;
   assign wready   = wr_en;
   assign wr_word  = awaddr[ADDR_W-1:2];
   assign wr_byte0 = wdata[7:0];
   assign wr_lane0 = wstrb[0];
   assign bvalid   = bvalid_q;
   assign bresp    = RESP_OKAY;

   assign unused_wr_bits = ^{awaddr[1:0], wdata[DATA_W-1:8], wstrb[STRB_W-1:1]};

   always_ff @(posedge clk) begin
      if (!rst_n)      bvalid_q <= 1'b0;
      else if (wr_en)  bvalid_q <= 1'b1;
      else if (bready) bvalid_q <= 1'b0;
   end

   assert_bresp_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (bvalid_q && !bready) |=> bvalid_q);

endmodule

// File: rtl/axil_rd_port.sv
module axil_rd_port
   import accel_ctrl_pkg::*;
#(
   parameter int ADDR_W = 6,
   parameter int DATA_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] araddr,
   input  logic              arvalid,
   output logic              arready,
   output logic [DATA_W-1:0] rdata,
   output logic [1:0]        rresp,
   output logic              rvalid,
   input  logic              rready,
   output logic              rd_en,
   output logic [ADDR_W-1:2] rd_word,
   input  logic [DATA_W-1:0] rd_value
);

   logic              rvalid_q;
   logic [DATA_W-1:0] rdata_q;
   logic              unused_rd_bits;

   assign rd_en   = arvalid & ~rvalid_q;
   assign arready = ~rvalid_q;
   assign rd_word = araddr[ADDR_W-1:2];
   assign rvalid  = rvalid_q;
   assign rdata   = rdata_q;
   assign rresp   = RESP_OKAY;

   assign unused_rd_bits = ^araddr[1:0];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rvalid_q <= 1'b0;
         rdata_q  <= '0;
      end else if (rd_en) begin
         rvalid_q <= 1'b1;
         rdata_q  <= rd_value;
      end else if (rready) begin
         rvalid_q <= 1'b0;
      end
   end

   assert_rdata_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (rvalid_q && !rready) |=> (rvalid_q && $stable(rdata_q)));

endmodule

// File: rtl/accel_ctrl_core.sv
module accel_ctrl_core
   import accel_ctrl_pkg::*;
#(
   parameter int ADDR_W  = 6,
   parameter int DATA_W  = 32,
   parameter bit IRQ_REG = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [ADDR_W-1:2] wr_word,
   input  logic [7:0]        wr_byte0,
   input  logic              wr_lane0,
   input  logic              rd_en,
   input  logic [ADDR_W-1:2] rd_word,
   output logic [DATA_W-1:0] rd_value,
   output logic              core_start,
   input  logic              core_done,
   input  logic              core_idle,
   input  logic              core_ready,
   output logic              irq
);

   logic             wr_hit, rd_hit;
   reg_sel_e         wr_sel, rd_sel;
   logic             wr_acc, wr_ctrl, wr_gie, wr_ier;
   logic             rd_clr_ctrl, rd_clr_isr;
   logic             start_q, done_q, rdy_q, auto_q, gie_q;
   logic [N_SRC-1:0] ier_q, isr_q, evt;
   logic             handshake, irq_src;

   if (ADDR_W > 4) begin : g_upper_decode
      assign wr_hit = (wr_word[ADDR_W-1:4] == '0);
      assign rd_hit = (rd_word[ADDR_W-1:4] == '0);
   end else begin : g_full_decode
      assign wr_hit = 1'b1;
      assign rd_hit = 1'b1;
   end

   assign wr_sel      = reg_sel_e'(wr_word[3:2]);
   assign rd_sel      = reg_sel_e'(rd_word[3:2]);
   assign wr_acc      = wr_en & wr_hit & wr_lane0;
   assign wr_ctrl     = wr_acc & (wr_sel == REG_CTRL);
   assign wr_gie      = wr_acc & (wr_sel == REG_GIE);
   assign wr_ier      = wr_acc & (wr_sel == REG_IER);
   assign rd_clr_ctrl = rd_en & rd_hit & (rd_sel == REG_CTRL);
   assign rd_clr_isr  = rd_en & rd_hit & (rd_sel == REG_ISR);

   assign handshake  = start_q & core_ready;
   assign evt        = {handshake, core_done};
   assign core_start = start_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         start_q <= 1'b0;
         done_q  <= 1'b0;
         rdy_q   <= 1'b0;
         auto_q  <= 1'b0;
         gie_q   <= 1'b0;
         ier_q   <= '0;
      end else begin
         start_q <= (start_q & ~core_ready)
                  | (wr_ctrl & wr_byte0[B_START])
                  | (auto_q & core_done);
         done_q  <= core_done | (done_q & ~rd_clr_ctrl);
         rdy_q   <= handshake | (rdy_q & ~rd_clr_ctrl);
         if (wr_ctrl) auto_q <= wr_byte0[B_AUTO];
         if (wr_gie)  gie_q  <= wr_byte0[0];
         if (wr_ier)  ier_q  <= wr_byte0[N_SRC-1:0];
      end
   end

   for (genvar i = 0; i < N_SRC; i++) begin : g_isr
      always_ff @(posedge clk) begin
         if (!rst_n) isr_q[i] <= 1'b0;
         else        isr_q[i] <= (evt[i] & ier_q[i]) | (isr_q[i] & ~rd_clr_isr);
      end
   end

   assign irq_src = gie_q & (|isr_q);

   if (IRQ_REG) begin : g_irq_flop
      logic irq_q;
      always_ff @(posedge clk) begin
         if (!rst_n) irq_q <= 1'b0;
         else        irq_q <= irq_src;
      end
      assign irq = irq_q;
   end else begin : g_irq_comb
      assign irq = irq_src;
   end

   always_comb begin
      rd_value = '0;
      if (rd_hit) begin
         unique case (rd_sel)
            REG_CTRL: begin
               rd_value[B_START] = start_q;
               rd_value[B_DONE]  = done_q;
               rd_value[B_IDLE]  = core_idle;
               rd_value[B_READY] = rdy_q;
               rd_value[B_AUTO]  = auto_q;
               rd_value[B_IRQ]   = irq;
            end
            REG_GIE: rd_value[0] = gie_q;
            REG_IER: rd_value[N_SRC-1:0] = ier_q;
            REG_ISR: rd_value[N_SRC-1:0] = isr_q;
            default: rd_value = '0;
         endcase
      end
   end

   assert_done_sticky_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (done_q && !rd_clr_ctrl) |=> done_q);

   assert_autorestart_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (auto_q && core_done) |=> core_start);

   assert_isr_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (isr_q[0] && rd_clr_isr && !core_done) |=> !isr_q[0]);

endmodule

// File: rtl/accel_ctrl_regs.sv
module accel_ctrl_regs
   import accel_ctrl_pkg::*;
#(
   parameter int ADDR_W  = 6,
   parameter int DATA_W  = 32,
   parameter bit IRQ_REG = 1'b0,
   localparam int STRB_W = DATA_W / 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] s_awaddr,
   input  logic              s_awvalid,
   output logic              s_awready,
   input  logic [DATA_W-1:0] s_wdata,
   input  logic [STRB_W-1:0] s_wstrb,
   input  logic              s_wvalid,
   output logic              s_wready,
   output logic [1:0]        s_bresp,
   output logic              s_bvalid,
   input  logic              s_bready,
   input  logic [ADDR_W-1:0] s_araddr,
   input  logic              s_arvalid,
   output logic              s_arready,
   output logic [DATA_W-1:0] s_rdata,
   output logic [1:0]        s_rresp,
   output logic              s_rvalid,
   input  logic              s_rready,
   output logic              core_start,
   input  logic              core_done,
   input  logic              core_idle,
   input  logic              core_ready,
   output logic              irq
);

   if (ADDR_W < 4) begin : g_bad_addr
      $error("accel_ctrl_regs: ADDR_W must cover four word registers");
   end
   if (DATA_W < 16 || (DATA_W % 8) != 0) begin : g_bad_data
      $error("accel_ctrl_regs: DATA_W must be a byte multiple of at least 16");
   end

   logic              wr_en, wr_lane0, rd_en;
   logic [ADDR_W-1:2] wr_word, rd_word;
   logic [7:0]        wr_byte0;
   logic [DATA_W-1:0] rd_value;

   axil_wr_port #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_wr (
      .clk      (clk),
      .rst_n    (rst_n),
      .awaddr   (s_awaddr),
      .awvalid  (s_awvalid),
      .awready  (s_awready),
      .wdata    (s_wdata),
      .wstrb    (s_wstrb),
      .wvalid   (s_wvalid),
      .wready   (s_wready),
      .bresp    (s_bresp),
      .bvalid   (s_bvalid),
      .bready   (s_bready),
      .wr_en    (wr_en),
      .wr_word  (wr_word),
      .wr_byte0 (wr_byte0),
      .wr_lane0 (wr_lane0)
   );

   axil_rd_port #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_rd (
      .clk      (clk),
      .rst_n    (rst_n),
      .araddr   (s_araddr),
      .arvalid  (s_arvalid),
      .arready  (s_arready),
      .rdata    (s_rdata),
      .rresp    (s_rresp),
      .rvalid   (s_rvalid),
      .rready   (s_rready),
      .rd_en    (rd_en),
      .rd_word  (rd_word),
      .rd_value (rd_value)
   );

   accel_ctrl_core #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .IRQ_REG(IRQ_REG)) u_core (
      .clk        (clk),
      .rst_n      (rst_n),
      .wr_en      (wr_en),
      .wr_word    (wr_word),
      .wr_byte0   (wr_byte0),
      .wr_lane0   (wr_lane0),
      .rd_en      (rd_en),
      .rd_word    (rd_word),
      .rd_value   (rd_value),
      .core_start (core_start),
      .core_done  (core_done),
      .core_idle  (core_idle),
      .core_ready (core_ready),
      .irq        (irq)
   );

endmodule

// File: tb/accel_ctrl_regs_tb.sv
module accel_ctrl_regs_tb;

   localparam int AW = 6;
   localparam int DW = 32;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [AW-1:0] s_awaddr = '0, s_araddr = '0;
   logic          s_awvalid = 1'b0, s_wvalid = 1'b0, s_arvalid = 1'b0;
   logic [DW-1:0] s_wdata = '0;
   logic [3:0]    s_wstrb = '0;
   logic          s_bready = 1'b1, s_rready = 1'b1;
   logic          core_done = 1'b0, core_idle = 1'b1, core_ready = 1'b0;
   logic          s_awready, s_wready, s_bvalid, s_arready, s_rvalid;
   logic [1:0]    s_bresp, s_rresp;
   logic [DW-1:0] s_rdata;
   logic          core_start, irq;

   int checks = 0;
   int errors = 0;
   int cycles = 0;
   bit rand_mode = 1'b0;
   bit started = 1'b0;

   always #5 clk = ~clk;

   accel_ctrl_regs #(.ADDR_W(AW), .DATA_W(DW)) u_dut (.*);

   task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h t=%0t", tag, act, exp, $time);
      end
   endtask

   // reference model
   bit         m_start, m_done, m_rdy, m_auto, m_gie, m_bvalid, m_rvalid;
   bit [1:0]   m_ier, m_isr;
   bit [31:0]  m_rdata;
   int         m_rd_idx;

   function automatic int word_of(logic [AW-1:0] a);
      if (a[AW-1:4] != 0) return -1;
      return int'(a[3:2]);
   endfunction

   function automatic bit [31:0] model_read(int idx);
      bit [31:0] v = 0;
      case (idx)
         0: begin
            v[0] = m_start; v[1] = m_done; v[2] = core_idle; v[3] = m_rdy;
            v[7] = m_auto;  v[9] = m_gie && (m_isr != 0);
         end
         1: v[0] = m_gie;
         2: v[1:0] = m_ier;
         3: v[1:0] = m_isr;
         default: v = 0;
      endcase
      return v;
   endfunction

   always @(posedge clk) begin
      bit wr, rd, hs, dn, wlane;
      int widx, ridx;
      bit [1:0] evt;
      started = 1'b1;
      if (!rst_n) begin
         m_start = 0; m_done = 0; m_rdy = 0; m_auto = 0; m_gie = 0;
         m_ier = 0; m_isr = 0; m_bvalid = 0; m_rvalid = 0; m_rdata = 0;
      end else begin
         wr = s_awvalid && s_wvalid && !m_bvalid;
         rd = s_arvalid && !m_rvalid;
         widx = word_of(s_awaddr);
         ridx = word_of(s_araddr);
         wlane = wr && s_wstrb[0];
         hs = m_start && core_ready;
         dn = core_done;
         evt = {hs, dn};
         if (rd) begin
            m_rdata = model_read(ridx);
            m_rd_idx = ridx;
         end
         m_start = (m_start && !core_ready) || (wlane && widx == 0 && s_wdata[0]) || (dn && m_auto);
         m_done = dn || (m_done && !(rd && ridx == 0));
         m_rdy = hs || (m_rdy && !(rd && ridx == 0));
         m_isr = (evt & m_ier) | (m_isr & ((rd && ridx == 3) ? 2'b00 : 2'b11));
         if (wlane && widx == 0) m_auto = s_wdata[7];
         if (wlane && widx == 1) m_gie = s_wdata[0];
         if (wlane && widx == 2) m_ier = s_wdata[1:0];
         if (wr) m_bvalid = 1; else if (s_bready) m_bvalid = 0;
         if (rd) m_rvalid = 1; else if (s_rready) m_rvalid = 0;
      end
   end

   always @(negedge clk) begin
      if (started) begin
         chk("R1 bvalid", {31'b0, s_bvalid}, {31'b0, m_bvalid});
         chk("R1 rvalid", {31'b0, s_rvalid}, {31'b0, m_rvalid});
         chk("R2 core_start", {31'b0, core_start}, {31'b0, m_start});
         chk("R8 irq", {31'b0, irq}, {31'b0, m_gie && (m_isr != 0)});
         if (m_bvalid) chk("R1 bresp", {30'b0, s_bresp}, 32'h0);
         if (m_rvalid) begin
            chk("R1 rresp", {30'b0, s_rresp}, 32'h0);
            case (m_rd_idx)
               0: chk("R3/R4 ctrl rdata", s_rdata, m_rdata);
               1, 2: chk("R6 enable rdata", s_rdata, m_rdata);
               3: chk("R7 status rdata", s_rdata, m_rdata);
               default: chk("R10 unmapped rdata", s_rdata, m_rdata);
            endcase
         end
      end
   end

   always @(posedge clk) begin
      cycles++;
      if (cycles > 150000) begin
         errors++;
         $display("FAIL watchdog expired after %0d cycles", cycles);
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   always @(posedge clk) begin
      #3;
      if (rand_mode) begin
         core_done  = ($urandom % 5) == 0;
         core_ready = ($urandom % 3) == 0;
         core_idle  = $urandom % 2;
         s_bready   = ($urandom % 4) != 0;
         s_rready   = ($urandom % 4) != 0;
      end
   end

   task automatic axi_write(logic [AW-1:0] a, logic [31:0] d, logic [3:0] st);
      bit got;
      @(posedge clk); #3;
      s_awaddr = a; s_wdata = d; s_wstrb = st;
      s_awvalid = 1; s_wvalid = 1;
      do begin
         @(negedge clk); got = s_awready && s_wready;
         @(posedge clk);
      end while (!got);
      #3; s_awvalid = 0; s_wvalid = 0;
      do begin
         @(negedge clk); got = s_bvalid && s_bready;
         @(posedge clk);
      end while (!got);
   endtask

   task automatic axi_read(logic [AW-1:0] a, output logic [31:0] d);
      bit got;
      @(posedge clk); #3;
      s_araddr = a; s_arvalid = 1;
      do begin
         @(negedge clk); got = s_arready;
         @(posedge clk);
      end while (!got);
      #3; s_arvalid = 0;
      do begin
         @(negedge clk); got = s_rvalid && s_rready; d = s_rdata;
         @(posedge clk);
      end while (!got);
   endtask

   task automatic pulse_done();
      @(posedge clk); #3 core_done = 1;
      @(posedge clk); #3 core_done = 0;
   endtask

   task automatic pulse_ready();
      @(posedge clk); #3 core_ready = 1;
      @(posedge clk); #3 core_ready = 0;
   endtask

   initial begin
      logic [31:0] rd;
      repeat (3) @(posedge clk);
      #3 rst_n = 1;
      @(negedge clk);
      chk("R2 reset start", {31'b0, core_start}, 0);
      chk("R8 reset irq", {31'b0, irq}, 0);
      chk("R1 reset bvalid", {31'b0, s_bvalid}, 0);

      axi_write(6'h04, 32'h1, 4'hF);
      axi_write(6'h08, 32'hFFFF_FFFF, 4'hF);
      axi_read(6'h04, rd); chk("R6 gie readback", rd, 32'h1);
      axi_read(6'h08, rd); chk("R6 ier reserved zero", rd, 32'h3);

      axi_write(6'h00, 32'h1, 4'h1);
      @(negedge clk); chk("R2 start set by write", {31'b0, core_start}, 1);
      axi_write(6'h00, 32'h0, 4'h1);
      @(negedge clk); chk("R2 write zero ignored", {31'b0, core_start}, 1);
      pulse_ready();
      @(negedge clk);
      chk("R2 start cleared by handshake", {31'b0, core_start}, 0);
      chk("R8 irq on ready source", {31'b0, irq}, 1);
      axi_read(6'h0C, rd); chk("R7 status ready bit", rd, 32'h2);
      @(negedge clk); chk("R7 status cleared by read", {31'b0, irq}, 0);
      axi_read(6'h00, rd); chk("R3 ready flag with idle R4", rd, 32'h0C);
      axi_read(6'h00, rd); chk("R3 flags cleared by read", rd, 32'h04);

      pulse_done();
      axi_read(6'h00, rd); chk("R3 done flag irq bit R8", rd, 32'h206);
      axi_read(6'h0C, rd); chk("R7 status done bit", rd, 32'h1);

      axi_write(6'h00, 32'h80, 4'h1);
      pulse_done();
      @(negedge clk); chk("R5 auto restart", {31'b0, core_start}, 1);
      axi_read(6'h00, rd); chk("R5 ctrl with auto", rd, 32'h287);
      axi_write(6'h0C, 32'h0, 4'hF);
      axi_read(6'h0C, rd); chk("R7 write to status ignored", rd, 32'h1);
      axi_write(6'h00, 32'h0, 4'h1);
      pulse_ready();
      axi_read(6'h0C, rd); chk("R7 ready after auto off", rd, 32'h2);
      axi_read(6'h00, rd); chk("R5 auto cleared", rd, 32'h0C);

      axi_write(6'h04, 32'h0, 4'hE);
      axi_read(6'h04, rd); chk("R9 lane0 strobe low", rd, 32'h1);

      axi_write(6'h10, 32'hFFFF_FFFF, 4'hF);
      axi_read(6'h10, rd); chk("R10 unmapped reads zero", rd, 32'h0);
      axi_read(6'h08, rd); chk("R10 unmapped write ignored", rd, 32'h3);

      // clearing read of 0x0 meets a done pulse on the same edge
      @(posedge clk); #3;
      s_araddr = 6'h00; s_arvalid = 1; core_done = 1;
      @(posedge clk); #3;
      s_arvalid = 0; core_done = 0;
      @(negedge clk); chk("R3 collision returns old value", s_rdata, 32'h04);
      @(posedge clk);
      axi_read(6'h00, rd); chk("R3 collision flag kept", rd, 32'h206);
      axi_read(6'h0C, rd); chk("R7 status after collision", rd, 32'h1);

      rand_mode = 1;
      for (int i = 0; i < 1500; i++) begin
         logic [AW-1:0] a;
         a = AW'(($urandom % 16) * 4);
         if ($urandom % 3 == 0)
            axi_write(a, $urandom, 4'($urandom));
         else
            axi_read(a, rd);
      end
      rand_mode = 0;
      @(posedge clk); #3;
      core_done = 0; core_ready = 0; s_bready = 1; s_rready = 1;
      repeat (5) @(posedge clk);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule